// File: doc/BRIEF.md
# Instruction Loop Buffer Stack

This block sits between instruction memory and the issue stage and keeps a short window of recently fetched instruction words. Each word is 60 bits and carries four instructions, so the default depth of eight words holds 32 instructions. A word returned by memory is written into the lowest slot while every older word moves one slot up. The oldest word falls off the top. Every slot keeps a valid bit and the word address it holds. The current program address is matched against all slots at once to find the word the issue stage sees.

In straight-line code the block fetches the next word once execution reaches the newest word, so only the two lowest slots hold live code. A branch whose target is already held in a slot is a hit. After a hit, refills stop and a loop runs entirely out of the buffer with no memory traffic. Refills resume when execution falls through past the newest word. A branch that misses clears every slot and fetches from the target.

A small state machine owns the fetch handshake. Its states are FILL (refills allowed, no request open), WAIT (request open, result wanted), DROP_FILL and DROP_LOOP (request open, result to be discarded, then return to FILL or LOOP), and LOOP (refills inhibited). Its transitions are:
- FILL to WAIT when a fetch is needed.
- WAIT to FILL when the word arrives.
- DROP_FILL to FILL and DROP_LOOP to LOOP when the stale word arrives.
- LOOP to FILL when the program address leaves the buffer.
- Any state to LOOP or DROP_LOOP on a branch hit.
- Any state to FILL or DROP_FILL on a branch miss. The DROP variant is taken while a request is still open.

Top module: `ilb_stack`

## Requirements
- R1: While reset is asserted, fetch_req, cur_valid, br_hit and br_miss are 0, and the program address is RESET_ADDR (0).
- R2: A word accepted from memory enters the lowest slot with the address it was fetched from, and all older words move up one slot. cur_valid is 1 exactly when the program address matches a valid slot, and cur_word is then the word fetched from that address.
- R3: When cur_valid and issue_req are both 1 and no branch is requested, cur_addr advances by one on the next cycle. In straight-line code a fetch opens for cur_addr+1 when cur_addr is the newest word, or for cur_addr itself when it is not held.
- R4: A branch whose target matches a valid slot gives br_hit=1 (and br_miss=0) for one cycle on the next cycle. From that cycle on, cur_word is the target word.
- R5: After a branch hit, fetch_req stays 0 for as long as the program address stays inside the buffer.
- R6: A branch whose target matches no valid slot gives br_miss=1 for one cycle on the next cycle. It invalidates every slot and then opens a fetch at the target address.
- R7: When execution in a captured loop runs past the newest word, the refill inhibit ends and a fetch opens at that next address.
- R8: Once raised, fetch_req and fetch_addr hold steady until mem_valid arrives unless a branch is requested. A word returned for a request that was open when a branch was requested (including the delivery cycle itself) is discarded.
- R9: Only the DEPTH most recent accepted words are held. A branch to a word pushed out of the top misses.
- R10: A branch request takes priority over issue_req in the same cycle: cur_addr becomes the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | One-cycle pulse: memory returns the requested word |
| mem_word | input | WORD_W | Returned instruction word |
| fetch_req | output | 1 | Fetch request, held until mem_valid |
| fetch_addr | output | ADDR_W | Word address of the open fetch |
| br_valid | input | 1 | Branch request from the issue stage |
| br_target | input | ADDR_W | Branch target word address |
| br_hit | output | 1 | Pulse: previous branch found its target in the buffer |
| br_miss | output | 1 | Pulse: previous branch missed and flushed the buffer |
| issue_req | input | 1 | Issue stage consumes the current word |
| cur_valid | output | 1 | Current word is present |
| cur_addr | output | ADDR_W | Current program word address |
| cur_word | output | WORD_W | Current instruction word |

## Verification
The bench builds the block with its defaults: DEPTH=8, ADDR_W=12 and WORD_W=60. Eight slots let a backward branch of nine or ten words fall just outside the window, so the eviction miss and the in-window hit both come up often. The 12-bit address space keeps far random targets from landing in the buffer by chance. A random memory latency of zero to three cycles places branches before, during and exactly on the delivery of an open fetch.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
    typedef enum logic [2:0] {
        ST_FILL,
        ST_WAIT,
        ST_DROP_FILL,
        ST_DROP_LOOP,
        ST_LOOP
    } ilb_state_e;
endpackage

// File: rtl/ilb_slots.sv
// Shifting word store with per-slot tags and parallel address compare.
module ilb_slots #(
    parameter int WORD_W = 60,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              flush,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [WORD_W-1:0] push_word,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              look_hit,
    output logic [WORD_W-1:0] look_word,
    output logic              probe_hit,
    output logic              bot_valid,
    output logic [ADDR_W-1:0] bot_addr
);
    logic [DEPTH-1:0]  vld;
    logic [ADDR_W-1:0] tag [DEPTH];
    logic [WORD_W-1:0] dat [DEPTH];
    logic [DEPTH-1:0]  m_look;
    logic [DEPTH-1:0]  m_probe;

    always_ff @(posedge clk) begin
        if (!rst_n)     vld <= '0;
        else if (flush) vld <= '0;
        else if (push)  vld <= {vld[DEPTH-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (push) begin
            tag[0] <= push_addr;
            dat[0] <= push_word;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (push) begin
                tag[i] <= tag[i-1];
                dat[i] <= dat[i-1];
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign m_look[i]  = vld[i] && (tag[i] == look_addr);
        assign m_probe[i] = vld[i] && (tag[i] == probe_addr);
    end

    always_comb begin
        look_word = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_look[i]) look_word = dat[i];
        end
    end

    assign look_hit  = |m_look;
    assign probe_hit = |m_probe;
    assign bot_valid = vld[0];
    assign bot_addr  = tag[0];
endmodule

// File: rtl/ilb_ctrl.sv
// Fetch/loop state machine and program address register.
module ilb_ctrl
    import ilb_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              issue_req,
    input  logic              mem_valid,
    input  logic              pc_hit,
    input  logic              probe_hit,
    input  logic              bot_valid,
    input  logic [ADDR_W-1:0] bot_addr,
    output logic [ADDR_W-1:0] pc,
    output logic              push,
    output logic              flush,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              br_hit,
    output logic              br_miss
);
    ilb_state_e st, nxt;
    logic busy, need;

    assign busy = (st == ST_WAIT) || (st == ST_DROP_FILL) || (st == ST_DROP_LOOP);
    assign need = !pc_hit || (bot_valid && (bot_addr == pc));

    always_comb begin
        nxt = st;
        if (br_valid) begin
            if (busy && !mem_valid) nxt = probe_hit ? ST_DROP_LOOP : ST_DROP_FILL;
            else                    nxt = probe_hit ? ST_LOOP      : ST_FILL;
        end else begin
            unique case (st)
                ST_FILL:      if (need)      nxt = ST_WAIT;
                ST_WAIT:      if (mem_valid) nxt = ST_FILL;
                ST_DROP_FILL: if (mem_valid) nxt = ST_FILL;
                ST_DROP_LOOP: if (mem_valid) nxt = ST_LOOP;
                ST_LOOP:      if (!pc_hit)   nxt = ST_FILL;
                default:                     nxt = ST_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_FILL;
            pc         <= RESET_ADDR;
            fetch_addr <= RESET_ADDR;
            br_hit     <= 1'b0;
            br_miss    <= 1'b0;
        end else begin
            st      <= nxt;
            br_hit  <= br_valid && probe_hit;
            br_miss <= br_valid && !probe_hit;
            if (br_valid)                 pc <= br_target;
            else if (issue_req && pc_hit) pc <= pc + ADDR_W'(1);
            if (st == ST_FILL && !br_valid && need)
                fetch_addr <= pc_hit ? pc + ADDR_W'(1) : pc;
        end
    end

    always_comb begin
        fetch_req = (st == ST_WAIT);
        push      = (st == ST_WAIT) && mem_valid && !br_valid;
        flush     = br_valid && !probe_hit;
    end
endmodule

// File: rtl/ilb_stack.sv
module ilb_stack #(
    parameter int                WORD_W     = 60,
    parameter int                ADDR_W     = 12,
    parameter int                DEPTH      = 8,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_word,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    output logic              br_hit,
    output logic              br_miss,
    input  logic              issue_req,
    output logic              cur_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_word
);
    logic              push, flush, pc_hit, probe_hit, bot_valid;
    logic [ADDR_W-1:0] pc, bot_addr;

    ilb_slots #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_slots (
        .clk(clk), .rst_n(rst_n), .push(push), .flush(flush),
        .push_addr(fetch_addr), .push_word(mem_word),
        .look_addr(pc), .probe_addr(br_target),
        .look_hit(pc_hit), .look_word(cur_word), .probe_hit(probe_hit),
        .bot_valid(bot_valid), .bot_addr(bot_addr)
    );

    ilb_ctrl #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
        .issue_req(issue_req), .mem_valid(mem_valid), .pc_hit(pc_hit),
        .probe_hit(probe_hit), .bot_valid(bot_valid), .bot_addr(bot_addr),
        .pc(pc), .push(push), .flush(flush), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .br_hit(br_hit), .br_miss(br_miss)
    );

    assign cur_valid = pc_hit;
    assign cur_addr  = pc;
endmodule

// File: rtl/ilb_stack_chk.sv
module ilb_stack_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_target,
    input logic              br_hit,
    input logic              br_miss,
    input logic              issue_req,
    input logic              cur_valid,
    input logic [ADDR_W-1:0] cur_addr
);
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(br_hit && br_miss)); // R4
    AST_BR_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) br_valid |=> (br_hit ^ br_miss)); // R6
    AST_NO_FETCH_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n) br_hit |-> !fetch_req); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (fetch_req && !mem_valid && !br_valid) |=> (fetch_req && $stable(fetch_addr))); // R8
    AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cur_valid && issue_req && !br_valid) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R3
    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n) br_valid |=> (cur_addr == $past(br_target))); // R10
endmodule

bind ilb_stack ilb_stack_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .br_valid(br_valid), .br_target(br_target),
    .br_hit(br_hit), .br_miss(br_miss), .issue_req(issue_req),
    .cur_valid(cur_valid), .cur_addr(cur_addr)
);

// File: tb/tb_ilb_stack.sv
module tb_ilb_stack;
    localparam int W = 60;
    localparam int A = 12;
    localparam int D = 8;

    logic clk = 0, rst_n = 0;
    logic mem_valid = 0, br_valid = 0, issue_req = 0;
    logic [W-1:0] mem_word = '0;
    logic [A-1:0] br_target = '0;
    logic fetch_req, br_hit, br_miss, cur_valid;
    logic [A-1:0] fetch_addr, cur_addr;
    logic [W-1:0] cur_word;

    ilb_stack dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [A-1:0] res_a [D];
    int res_n = 0;
    logic [A-1:0] m_pc = '0;
    bit lock = 0, busy = 0, stale = 0, hit_exp = 0;
    int cnt = 0;
    logic [A-1:0] pa = '0;
    bit d_br = 0, d_iss = 0, d_mv = 0;
    logic [A-1:0] d_tgt = '0;
    bit fr_prev = 0, cv_prev = 0;
    logic [A-1:0] fa_prev = '0;

    function automatic logic [W-1:0] memfn(logic [A-1:0] a);
        return {4'hA, a, ~a, a ^ 12'h5A5, a + 12'd7, 8'h3C};
    endfunction

    function automatic bit is_res(logic [A-1:0] a);
        for (int i = 0; i < res_n; i++) if (res_a[i] == a) return 1;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic push_res(logic [A-1:0] a);
        for (int i = D - 1; i > 0; i--) res_a[i] = res_a[i-1];
        res_a[0] = a;
        if (res_n < D) res_n++;
    endtask

    // one cycle: update model for last edge, check, then drive next inputs
    task automatic cycle(bit br, logic [A-1:0] tgt, bit iss);
        @(negedge clk);
        if (!busy && fr_prev) begin
            busy = 1; pa = fa_prev; stale = 0; cnt = $urandom_range(0, 3);
        end
        if (d_mv) begin
            if (!stale && !d_br) push_res(pa);
            busy = 0;
        end
        if (d_br && busy) stale = 1;
        if (d_br) begin
            hit_exp = is_res(d_tgt);
            if (hit_exp) lock = 1;
            else begin res_n = 0; lock = 0; end
            m_pc = d_tgt;
        end else if (d_iss && cv_prev) m_pc = m_pc + 1'b1;
        if (lock && !is_res(m_pc)) lock = 0;

        chk(cur_addr == m_pc, "R3 R10 cur_addr", 64'(cur_addr), 64'(m_pc));
        chk(cur_valid == is_res(m_pc), "R2 R9 cur_valid", 64'(cur_valid), 64'(is_res(m_pc)));
        if (cur_valid) chk(cur_word == memfn(cur_addr), "R2 cur_word", 64'(cur_word), 64'(memfn(cur_addr)));
        chk(br_hit == (d_br && hit_exp), "R4 R9 br_hit", 64'(br_hit), 64'(d_br && hit_exp));
        chk(br_miss == (d_br && !hit_exp), "R6 R9 br_miss", 64'(br_miss), 64'(d_br && !hit_exp));
        if (lock && is_res(m_pc)) chk(!fetch_req, "R5 no refill in loop", 64'(fetch_req), 64'(0));
        if (fetch_req && !fr_prev) begin
            logic [A-1:0] ea;
            ea = is_res(m_pc) ? m_pc + 1'b1 : m_pc;
            chk(fetch_addr == ea, "R3 R6 R7 fetch_addr", 64'(fetch_addr), 64'(ea));
        end
        if (fr_prev && !d_mv && !d_br)
            chk(fetch_req && fetch_addr == fa_prev, "R8 request held", 64'(fetch_addr), 64'(fa_prev));

        fr_prev = fetch_req; cv_prev = cur_valid; fa_prev = fetch_addr;
        d_br = br; d_tgt = tgt; d_iss = iss;
        d_mv = 0;
        if (busy) begin
            if (cnt == 0) d_mv = 1; else cnt--;
        end
        br_valid = br; br_target = tgt; issue_req = iss;
        mem_valid = d_mv; mem_word = d_mv ? memfn(pa) : '0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!fetch_req && !cur_valid && !br_hit && !br_miss && cur_addr == '0,
            "R1 reset state", {fetch_req, cur_valid, br_hit, br_miss}, 64'(0));
        rst_n = 1;
        // directed: straight line, then in-window loop, then evicted target
        repeat (40) cycle(0, '0, 1);
        cycle(1, m_pc - 12'd3, 0);               // R4 expected hit
        repeat (12) cycle(0, '0, 1);
        cycle(1, m_pc - 12'd4, 1);               // R4 R10 loop again
        repeat (20) cycle(0, '0, 1);             // R7 fall through
        repeat (30) cycle(0, '0, 1);
        cycle(1, m_pc - 12'd10, 1);              // R9 evicted: miss
        repeat (20) cycle(0, '0, 1);
        cycle(1, 12'h800, 0);                    // R6 far miss
        cycle(1, 12'h800, 0);                    // R8 branch while fetch open
        repeat (20) cycle(0, '0, 1);
        // random mix
        for (int k = 0; k < 6000; k++) begin
            bit br, iss;
            logic [A-1:0] t;
            int sel;
            br  = ($urandom_range(0, 9) == 0);
            iss = ($urandom_range(0, 3) != 0);
            sel = $urandom_range(0, 3);
            if (sel < 2)       t = m_pc - A'($urandom_range(0, 10));
            else if (sel == 2) t = m_pc + A'($urandom_range(1, 3));
            else               t = A'($urandom);
            cycle(br, t, iss);
        end
        repeat (6) cycle(0, '0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule